// File: doc/BRIEF.md
# Burst Frame Reader

This block pulls a stored video frame out of an external memory controller and feeds it to a display pixel FIFO. It issues one read request at a time. Each request covers a fixed burst of 32-bit words. The block waits for the controller to accept the request. It then forwards every returned data beat into the FIFO. Once the whole burst has landed, it steps to the next burst address, and only after that does it consider issuing another request.

Two enables gate the block: a start-up completion flag and a run flag. A request also needs enough free space in the pixel FIFO to absorb a whole burst. Addresses advance by one burst's worth of bytes. After one complete frame has been read, the address returns to the frame base, so a static frame is scanned over and over for as long as the run flag stays high. If the run flag drops in the middle of a burst, that burst still completes, and no further request follows.

Top module: `burst_frame_reader`

## Requirements
- R1: While idle, `rd_req` rises only in the cycle after one in which `init_done` and `run_en` were both high; with either enable low, no request is issued.
- R2: A request is issued only after a cycle in which the FIFO free space (`FIFO_DEPTH - fifo_level`) was at least `BURST_WORDS`. With less room than that, the block stays idle.
- R3: Once raised, `rd_req` stays high with `rd_addr` unchanged until a cycle with `rd_ack` high. `rd_req` is low in the following cycle.
- R4: After an accepted request, exactly `BURST_WORDS` beats with `rd_valid` high are written to the FIFO. For each one, `fifo_wr` is high in the same cycle and `fifo_wdata` equals `rd_data`. `rd_valid` has no effect while idle, while a request is waiting, or after the last beat of the burst.
- R5: Each burst's request address is the previous burst's address plus `BURST_WORDS * WORD_BYTES`, except at the frame wrap.
- R6: After `FRAME_WORDS / BURST_WORDS` bursts, the next request address is `FRAME_BASE` again.
- R7: If `run_en` falls after a request was accepted, the burst in flight still delivers all of its beats. No further request is issued until `run_en` returns. The next request then continues at the following address.
- R8: While `rst_n` is low, `rd_req` and `fifo_wr` are low and `rd_addr` equals `FRAME_BASE`. The first request after reset uses `FRAME_BASE`.
- R9: With both enables high and room available, `rd_req` is low in the two cycles that follow the cycle carrying the last beat of a burst, and high in the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| init_done | input | 1 | Memory start-up complete enable |
| run_en | input | 1 | Streaming enable |
| rd_req | output | 1 | Burst read request to the memory controller |
| rd_addr | output | ADDR_W | Byte address of the requested burst |
| rd_ack | input | 1 | Controller accepts the pending request |
| rd_valid | input | 1 | Read data beat valid |
| rd_data | input | DATA_W | Read data beat |
| fifo_level | input | $clog2(FIFO_DEPTH+1) | Current pixel FIFO fill count in words |
| fifo_wr | output | 1 | Pixel FIFO write strobe |
| fifo_wdata | output | DATA_W | Pixel FIFO write data |

## Verification
The bench builds the block with `BURST_WORDS` = 8, `FIFO_DEPTH` = 16, `FRAME_WORDS` = 32 and a non-zero `FRAME_BASE`. A frame is therefore four bursts long, so the address wrap comes after only a handful of bursts and can be seen more than once along with the reset address. The small FIFO puts the room threshold between fill levels 8 and 9, so a one-word difference decides whether a request is issued. Varied acknowledge delays, gaps between beats, and stray valid strobes around the data phase exercise the handshake and the beat count.

// File: rtl/bfr_pkg.sv
// Package for the burst frame reader: shared state encoding.
// Assumes nothing beyond a single clock domain.
package bfr_pkg;

    // Controller phases: wait for permission, hold request, collect beats, step address.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REQ  = 2'd1,
        PH_DATA = 2'd2,
        PH_STEP = 2'd3
    } bfr_phase_t;

endpackage

// File: rtl/bfr_issue_gate.sv
// Issue gate: combines both enables with a room check on the pixel FIFO.
// Assumes fifo_level is a word count in 0..FIFO_DEPTH; larger values
// count as no room.
module bfr_issue_gate #(
    parameter int unsigned BURST_WORDS = 8,
    parameter int unsigned FIFO_DEPTH  = 512,
    localparam int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             init_done,
    input  logic             run_en,
    input  logic [LVL_W-1:0] fifo_level,
    output logic             issue_ok
);

    // Highest fill level that still leaves space for one full burst.
    localparam logic [LVL_W-1:0] ROOM_MAX = LVL_W'(FIFO_DEPTH - BURST_WORDS);

    logic has_room;

    // Room test: free space of at least one burst.
    always_comb begin
        has_room = (fifo_level <= ROOM_MAX);
    end

    // Permission: both enables high and room available.
    always_comb begin
        issue_ok = init_done && run_en && has_room;
    end

endmodule

// File: rtl/bfr_beat_counter.sv
// Beat counter: counts accepted data beats inside one burst.
// Clears when a request is accepted; flags the final beat of the burst.
// Assumes BURST_WORDS >= 2.
module bfr_beat_counter #(
    parameter int unsigned BURST_WORDS = 8,
    localparam int unsigned CNT_W      = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BURST_WORDS - 1);

    logic [CNT_W-1:0] cnt_q;

    // Final-beat flag: the current beat index is the burst's last.
    always_comb begin
        last = (cnt_q == LAST_CNT);
    end

    // Beat index register: reset and clear to zero, step per accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            if (cnt_q == LAST_CNT) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/bfr_addr_gen.sv
// Address generator: holds the byte address of the next burst and
// advances it by one burst per step pulse, returning to FRAME_BASE once
// a whole frame has been covered. Assumes FRAME_WORDS is a multiple of
// BURST_WORDS.
module bfr_addr_gen #(
    parameter int unsigned          ADDR_W      = 32,
    parameter int unsigned          WORD_BYTES  = 4,
    parameter int unsigned          BURST_WORDS = 8,
    parameter int unsigned          FRAME_WORDS = 640 * 480,
    parameter logic [ADDR_W-1:0]    FRAME_BASE  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);

    localparam int unsigned BURSTS = FRAME_WORDS / BURST_WORDS;
    localparam int unsigned IDX_W  = (BURSTS > 1) ? $clog2(BURSTS) : 1;
    localparam logic [ADDR_W-1:0] STRIDE   = ADDR_W'(BURST_WORDS * WORD_BYTES);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'((BURSTS > 0) ? BURSTS - 1 : 0);

    logic [ADDR_W-1:0] addr_q;

    generate
        if (BURSTS > 1) begin : g_multi
            logic [IDX_W-1:0] idx_q;

            // Burst index and address: step forward, wrap at frame end.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    idx_q  <= '0;
                    addr_q <= FRAME_BASE;
                end else if (step) begin
                    if (idx_q == LAST_IDX) begin
                        idx_q  <= '0;
                        addr_q <= FRAME_BASE;
                    end else begin
                        idx_q  <= idx_q + IDX_W'(1);
                        addr_q <= addr_q + STRIDE;
                    end
                end
            end
        end else begin : g_single
            // Single-burst frame: the address never moves.
            always_ff @(posedge clk) begin
                if (!rst_n || step) begin
                    addr_q <= FRAME_BASE;
                end
            end
        end
    endgenerate

    // Output the registered address.
    always_comb begin
        addr = addr_q;
    end

endmodule

// File: rtl/bfr_ctrl_fsm.sv
// Control sequencer: waits for permission, holds the request until it
// is accepted, collects one burst of beats, then spends one cycle on the
// address step before going back to idle. Assumes the controller
// returns exactly one burst of beats per accepted request.
module bfr_ctrl_fsm
    import bfr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic issue_ok,
    input  logic rd_ack,
    input  logic rd_valid,
    input  logic last_beat,
    output logic req,
    output logic beat_take,
    output logic cnt_clr,
    output logic step
);

    bfr_phase_t phase_q;
    bfr_phase_t phase_d;

    // Next-phase selection.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (issue_ok)               phase_d = PH_REQ;
            PH_REQ:  if (rd_ack)                 phase_d = PH_DATA;
            PH_DATA: if (rd_valid && last_beat)  phase_d = PH_STEP;
            PH_STEP:                             phase_d = PH_IDLE;
            default:                             phase_d = PH_IDLE;
        endcase
    end

    // Phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Phase-decoded strobes for the datapath.
    always_comb begin
        req       = (phase_q == PH_REQ);
        cnt_clr   = (phase_q == PH_REQ) && rd_ack;
        beat_take = (phase_q == PH_DATA) && rd_valid;
        step      = (phase_q == PH_STEP);
    end

endmodule

// File: rtl/burst_frame_reader.sv
// Burst frame reader top: reads a frame from a memory controller in
// fixed-size bursts and forwards returned words straight into a pixel
// FIFO. Assumes the controller accepts one request at a time and that
// the FIFO level reflects writes with at most a one-cycle lag, which
// is covered because the room test runs only between bursts.
module burst_frame_reader #(
    parameter int unsigned       DATA_W      = 32,
    parameter int unsigned       ADDR_W      = 32,
    parameter int unsigned       WORD_BYTES  = 4,
    parameter int unsigned       BURST_WORDS = 8,
    parameter int unsigned       FRAME_WORDS = 640 * 480,
    parameter int unsigned       FIFO_DEPTH  = 512,
    parameter logic [ADDR_W-1:0] FRAME_BASE  = '0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              init_done,
    input  logic                              run_en,
    output logic                              rd_req,
    output logic [ADDR_W-1:0]                 rd_addr,
    input  logic                              rd_ack,
    input  logic                              rd_valid,
    input  logic [DATA_W-1:0]                 rd_data,
    input  logic [$clog2(FIFO_DEPTH+1)-1:0]   fifo_level,
    output logic                              fifo_wr,
    output logic [DATA_W-1:0]                 fifo_wdata
);

    logic issue_ok;
    logic last_beat;
    logic beat_take;
    logic cnt_clr;
    logic step;

    bfr_issue_gate #(
        .BURST_WORDS (BURST_WORDS),
        .FIFO_DEPTH  (FIFO_DEPTH)
    ) u_gate (
        .init_done  (init_done),
        .run_en     (run_en),
        .fifo_level (fifo_level),
        .issue_ok   (issue_ok)
    );

    bfr_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_ok  (issue_ok),
        .rd_ack    (rd_ack),
        .rd_valid  (rd_valid),
        .last_beat (last_beat),
        .req       (rd_req),
        .beat_take (beat_take),
        .cnt_clr   (cnt_clr),
        .step      (step)
    );

    bfr_beat_counter #(
        .BURST_WORDS (BURST_WORDS)
    ) u_beats (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (beat_take),
        .last  (last_beat)
    );

    bfr_addr_gen #(
        .ADDR_W      (ADDR_W),
        .WORD_BYTES  (WORD_BYTES),
        .BURST_WORDS (BURST_WORDS),
        .FRAME_WORDS (FRAME_WORDS),
        .FRAME_BASE  (FRAME_BASE)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .addr  (rd_addr)
    );

    // FIFO write path: accepted beats pass through in the same cycle.
    always_comb begin
        fifo_wr    = beat_take;
        fifo_wdata = rd_data;
    end

endmodule

// File: rtl/bfr_checker.sv
// Protocol checker for the burst frame reader, attached by bind.
// Tracks the beats of each accepted burst and the last accepted address.
module bfr_checker #(
    parameter int unsigned       DATA_W      = 32,
    parameter int unsigned       ADDR_W      = 32,
    parameter int unsigned       WORD_BYTES  = 4,
    parameter int unsigned       BURST_WORDS = 8,
    parameter int unsigned       FIFO_DEPTH  = 512,
    parameter logic [ADDR_W-1:0] FRAME_BASE  = '0,
    localparam int unsigned      LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_done,
    input logic              run_en,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ack,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [LVL_W-1:0]  fifo_level,
    input logic              fifo_wr,
    input logic [DATA_W-1:0] fifo_wdata
);

    localparam int unsigned       BW       = $clog2(BURST_WORDS + 1);
    localparam logic [BW-1:0]     FULL     = BW'(BURST_WORDS);
    localparam logic [BW-1:0]     PRE_LAST = BW'(BURST_WORDS - 1);
    localparam logic [LVL_W-1:0]  ROOM_MAX = LVL_W'(FIFO_DEPTH - BURST_WORDS);
    localparam logic [ADDR_W-1:0] STRIDE   = ADDR_W'(BURST_WORDS * WORD_BYTES);

    logic [BW-1:0]     beats_q;
    logic              seen_q;
    logic [ADDR_W-1:0] prev_addr_q;

    // Burst tracking: clear on acceptance, count FIFO writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beats_q     <= '0;
            seen_q      <= 1'b0;
            prev_addr_q <= FRAME_BASE;
        end else if (rd_req && rd_ack) begin
            beats_q     <= '0;
            seen_q      <= 1'b1;
            prev_addr_q <= rd_addr;
        end else if (fifo_wr) begin
            beats_q <= beats_q + BW'(1);
        end
    end

    // R1
    enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req) |-> ($past(init_done) && $past(run_en)));

    // R2
    room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req) |-> ($past(fifo_level) <= ROOM_MAX));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    // R3
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack) |=> !rd_req);

    // R4
    wr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (rd_valid && !rd_req && fifo_wdata == rd_data));

    // R4
    beat_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (beats_q < FULL));

    // R4
    burst_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_req) && seen_q) |-> (beats_q == FULL));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_req) && seen_q) |->
            (rd_addr == prev_addr_q + STRIDE || rd_addr == FRAME_BASE));

    // R8
    first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !seen_q) |-> (rd_addr == FRAME_BASE));

    // R9
    spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && beats_q == PRE_LAST) |=> (!rd_req ##1 !rd_req));

endmodule

bind burst_frame_reader bfr_checker #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .WORD_BYTES  (WORD_BYTES),
    .BURST_WORDS (BURST_WORDS),
    .FIFO_DEPTH  (FIFO_DEPTH),
    .FRAME_BASE  (FRAME_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_done  (init_done),
    .run_en     (run_en),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_ack     (rd_ack),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .fifo_level (fifo_level),
    .fifo_wr    (fifo_wr),
    .fifo_wdata (fifo_wdata)
);

// File: tb/burst_frame_reader_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the memory responder task pushes each returned
// word into a queue, and a monitor pops and compares every FIFO write.
module burst_frame_reader_tb;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned BURST  = 8;
    localparam int unsigned FRAME  = 32;
    localparam int unsigned DEPTH  = 16;
    localparam int unsigned LVL_W  = $clog2(DEPTH + 1);
    localparam logic [ADDR_W-1:0] BASE = 32'h0000_4000;
    localparam int unsigned PER_FRAME = FRAME / BURST;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              init_done;
    logic              run_en;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_ack;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic [LVL_W-1:0]  fifo_level;
    logic              fifo_wr;
    logic [DATA_W-1:0] fifo_wdata;

    int checks = 0;
    int errors = 0;
    int bursts_done = 0;
    logic [DATA_W-1:0] exp_q[$];

    burst_frame_reader #(
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .WORD_BYTES  (4),
        .BURST_WORDS (BURST),
        .FRAME_WORDS (FRAME),
        .FIFO_DEPTH  (DEPTH),
        .FRAME_BASE  (BASE)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_done  (init_done),
        .run_en     (run_en),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_ack     (rd_ack),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .fifo_level (fifo_level),
        .fifo_wr    (fifo_wr),
        .fifo_wdata (fifo_wdata)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] addr_of(input int n);
        return BASE + ADDR_W'((n % PER_FRAME) * BURST * 4);
    endfunction

    // Monitor: every FIFO write must match the next expected word.
    always @(negedge clk) begin
        #1;
        if (rst_n && fifo_wr) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4", "unexpected fifo write", 32'd1, 32'd0);
            end else begin
                logic [DATA_W-1:0] w;
                w = exp_q.pop_front();
                check(fifo_wdata == w, "R4", "fifo data", fifo_wdata, w);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (60000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // One cycle: drive at the falling edge, sample one ns later.
    task automatic idle_cycles(input int n, input string req, input bit req_exp);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            check(rd_req == req_exp, req, "rd_req level", {31'd0, rd_req}, {31'd0, req_exp});
        end
    endtask

    // Memory responder: answers one request with one burst.
    task automatic serve(input int ack_delay, input int gap, input bit stray,
                         input bit gap_chk, input bit drop_run, input string addr_req);
        logic [ADDR_W-1:0] exp_a;
        logic [ADDR_W-1:0] held;
        int w;
        exp_a = addr_of(bursts_done);
        w = 0;
        while (!rd_req && w < 40) begin
            @(negedge clk);
            #1;
            w++;
        end
        check(rd_req == 1'b1, addr_req, "request seen", {31'd0, rd_req}, 32'd1);
        check(rd_addr == exp_a, addr_req, "request address", rd_addr, exp_a);
        held = rd_addr;
        for (int i = 0; i < ack_delay; i++) begin
            @(negedge clk);
            rd_valid = stray;
            #1;
            check(rd_req && rd_addr == held, "R3", "request held", rd_addr, held);
            if (stray) check(!fifo_wr, "R4", "valid before ack", {31'd0, fifo_wr}, 32'd0);
        end
        @(negedge clk);
        rd_valid = 1'b0;
        rd_ack = 1'b1;
        if (drop_run) run_en = 1'b0;
        #1;
        @(negedge clk);
        rd_ack = 1'b0;
        #1;
        check(!rd_req, "R3", "request dropped after ack", {31'd0, rd_req}, 32'd0);
        for (int b = 0; b < int'(BURST); b++) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                rd_valid = 1'b0;
                #1;
            end
            @(negedge clk);
            rd_valid = 1'b1;
            rd_data = exp_a ^ (32'h0101_0101 * b) ^ 32'hC0DE_0000;
            exp_q.push_back(rd_data);
            #1;
        end
        bursts_done++;
        if (gap_chk) begin
            for (int k = 1; k <= 3; k++) begin
                @(negedge clk);
                rd_valid = stray;
                #1;
                check(rd_req == (k == 3), "R9", "request spacing", {31'd0, rd_req}, {31'd0, k == 3});
                if (stray) check(!fifo_wr, "R4", "valid after burst", {31'd0, fifo_wr}, 32'd0);
            end
        end else begin
            @(negedge clk);
            rd_valid = stray;
            #1;
            check(!fifo_wr, "R4", "no write after last beat", {31'd0, fifo_wr}, 32'd0);
        end
        check(exp_q.size() == 0, drop_run ? "R7" : "R4", "all beats written", exp_q.size(), 32'd0);
    endtask

    initial begin
        rst_n = 1'b0;
        init_done = 1'b1;
        run_en = 1'b1;
        rd_ack = 1'b0;
        rd_valid = 1'b1;
        rd_data = '0;
        fifo_level = '0;
        repeat (3) @(negedge clk);
        #1;
        // R8: reset state
        check(!rd_req, "R8", "rd_req in reset", {31'd0, rd_req}, 32'd0);
        check(!fifo_wr, "R8", "fifo_wr in reset", {31'd0, fifo_wr}, 32'd0);
        check(rd_addr == BASE, "R8", "address in reset", rd_addr, BASE);

        @(negedge clk);
        rst_n = 1'b1;
        init_done = 1'b0;
        rd_valid = 1'b0;
        #1;
        idle_cycles(8, "R1", 1'b0);        // R1: init_done low blocks
        @(negedge clk);
        init_done = 1'b1;
        run_en = 1'b0;
        rd_valid = 1'b1;                   // R4: stray beats while idle
        #1;
        check(!fifo_wr, "R4", "valid while idle", {31'd0, fifo_wr}, 32'd0);
        idle_cycles(8, "R1", 1'b0);        // R1: run_en low blocks
        @(negedge clk);
        rd_valid = 1'b0;
        run_en = 1'b1;
        fifo_level = LVL_W'(DEPTH - BURST + 1);
        #1;
        idle_cycles(8, "R2", 1'b0);        // R2: one word short of room
        @(negedge clk);
        fifo_level = LVL_W'(DEPTH - BURST);
        #1;
        @(negedge clk);
        #1;
        check(rd_req, "R2", "request once room exists", {31'd0, rd_req}, 32'd1);

        serve(3, 0, 1'b1, 1'b1, 1'b0, "R8");   // first burst at base
        serve(0, 1, 1'b0, 1'b0, 1'b0, "R5");
        serve(2, 2, 1'b1, 1'b1, 1'b0, "R5");
        serve(1, 0, 1'b1, 1'b0, 1'b0, "R5");
        serve(0, 0, 1'b0, 1'b1, 1'b0, "R6");   // frame wrap
        @(negedge clk);
        rd_valid = 1'b0;
        #1;
        serve(1, 1, 1'b0, 1'b0, 1'b1, "R5");   // run drops mid burst
        @(negedge clk);
        rd_valid = 1'b0;
        #1;
        idle_cycles(12, "R7", 1'b0);       // R7: no request after stop
        @(negedge clk);
        run_en = 1'b1;
        #1;
        serve(0, 0, 1'b0, 1'b0, 1'b0, "R7");   // R7: resumes at next address
        @(negedge clk);
        rd_valid = 1'b0;
        run_en = 1'b0;
        #1;
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule